// File: doc/BRIEF.md
# Hierarchical Vertical-Crosswise Unsigned Multiplier

This block multiplies two unsigned operands of equal width and returns the full double-width product in one combinational step. No clock, register or handshake is involved. It is meant to be dropped into a datapath wherever a small multiply must settle within a single cycle of the surrounding logic.

The product is built by recursion. Each operand is split into a high half and a low half. The four half-width products (low by low, low by high, high by low, high by high) are formed in parallel and then merged by three ripple-carry adders. At the bottom of the recursion sits a 2x2 cell. Its low bit is the vertical term a0·b0. Its next bit is the crosswise sum a0·b1 + a1·b0. Its top two bits come from the vertical term a1·b1 plus the carry of that crosswise sum. A 4-bit multiplier therefore uses four 2x2 cells and three 4-bit adders. The 8-bit multiplier applies the same structure one level up, with four 4-bit units and three 8-bit adders.

Top module: `vc_mult`

## Requirements
- R1: With WIDTH = 8, `prod` equals the unsigned product of `op_a` and `op_b` for every one of the 65,536 operand pairs.
- R2: With WIDTH = 4, the 8-bit `prod` equals the unsigned product of the operands for every one of the 256 operand pairs.
- R3: The product is never truncated. All-ones operands give 16'hFE01 at WIDTH = 8 and 8'hE1 at WIDTH = 4, and no result ever exceeds (2^WIDTH − 1)^2.
- R4: Bit 0 of `prod` equals op_a[0] AND op_b[0].
- R5: If either operand is zero, `prod` is zero.
- R6: If one operand is 1, `prod` equals the other operand, zero-extended.
- R7: At WIDTH = 4, operands 4'b0100 and 4'b0100 give `prod` = 8'b00010000.
- R8: The block holds no state. `prod` follows a change on the operands within the same time step, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | Unsigned multiplicand |
| op_b | input | WIDTH | Unsigned multiplier |
| prod | output | 2*WIDTH | Unsigned product, full width |

## Verification
The riskiest point is where the carries from the cross-product sum and from the middle-column sum meet before entering the top adder. If one of those carries were dropped, products with large cross terms (such as 8'hFF × 8'hFF or 8'hF0 × 8'h0F) would come out low by 2^(WIDTH+WIDTH/2). The bench therefore sweeps every operand pair at both widths and targets the all-ones corner directly. It also checks the zero and unity operands and bit 0 of the product. A misrouted low half of the low×low product would break the unity cases, and a swapped cross term would break asymmetric pairs. The bench changes the operands between clock edges and samples the result, so any hidden register or latch would show a stale product.

// File: rtl/vc_mul_pkg.sv
// Shared helpers for the vertical-crosswise multiplier.
// Assumes operand widths are powers of two, 2 or larger.
package vc_mul_pkg;

    // Width of the full product for a given operand width.
    function automatic int prod_width(input int w);
        return 2 * w;
    endfunction

    // Width of one half-operand at a given recursion level.
    function automatic int half_width(input int w);
        return w / 2;
    endfunction

endpackage

// File: rtl/vc_cell2.sv
// 2x2 base cell: forms a 4-bit product from the vertical terms
// (a0.b0, a1.b1) and the crosswise terms (a0.b1, a1.b0).
// Assumes: purely combinational, unsigned operands.
module vc_cell2 (
    input  logic [1:0] x,
    input  logic [1:0] y,
    output logic [3:0] p
);

    logic v_lo, v_hi, x_lo, x_hi, x_carry;

    // Bit products: the two vertical terms and the two crosswise terms.
    always_comb begin
        v_lo = x[0] & y[0];
        v_hi = x[1] & y[1];
        x_lo = x[0] & y[1];
        x_hi = x[1] & y[0];
    end

    // Crosswise sum forms bit 1; its carry joins the high vertical term.
    always_comb begin
        x_carry = x_lo & x_hi;
        p[0]    = v_lo;
        p[1]    = x_lo ^ x_hi;
        p[2]    = v_hi ^ x_carry;
        p[3]    = v_hi & x_carry;
    end

endmodule

// File: rtl/vc_rca.sv
// Ripple-carry adder of parameter width with carry in and carry out.
// Assumes: W >= 1; the carry chain is a plain linear ripple.
module vc_rca #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         cout
);

    logic [W:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // One full-adder stage of the ripple chain.
        always_comb begin
            s[i]       = x[i] ^ y[i] ^ chain[i];
            chain[i+1] = (x[i] & y[i]) | (chain[i] & (x[i] ^ y[i]));
        end
    end

    assign cout = chain[W];

endmodule

// File: rtl/vc_mul_node.sv
// One level of the recursive multiplier. For W == 2 it is the base
// cell. Otherwise it splits each operand into halves, forms four
// half-width products with child nodes and merges them with three
// W-bit ripple-carry adders.
// Assumes: W is a power of two, 2 or larger.
module vc_mul_node
    import vc_mul_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);

    localparam int H = half_width(W);

    if (W == 2) begin : g_base
        vc_cell2 u_cell (.x(a), .y(b), .p(p));
    end else begin : g_split
        logic [W-1:0] pr_ll, pr_lh, pr_hl, pr_hh;
        logic [W-1:0] cross_s, mid_s, top_s;
        logic [W-1:0] mid_addend, top_addend;
        logic         cross_c, mid_c, top_carry_unused;

        vc_mul_node #(.W(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(pr_ll));
        vc_mul_node #(.W(H)) u_lh (.a(a[H-1:0]), .b(b[W-1:H]), .p(pr_lh));
        vc_mul_node #(.W(H)) u_hl (.a(a[W-1:H]), .b(b[H-1:0]), .p(pr_hl));
        vc_mul_node #(.W(H)) u_hh (.a(a[W-1:H]), .b(b[W-1:H]), .p(pr_hh));

        // Stage 1: sum of the two cross products.
        vc_rca #(.W(W)) u_add_cross (
            .x(pr_lh), .y(pr_hl), .cin(1'b0), .s(cross_s), .cout(cross_c)
        );

        // Upper half of the low-by-low product, aligned for stage 2.
        always_comb mid_addend = {{H{1'b0}}, pr_ll[W-1:H]};

        // Stage 2: cross sum plus the upper half of low-by-low.
        vc_rca #(.W(W)) u_add_mid (
            .x(cross_s), .y(mid_addend), .cin(1'b0), .s(mid_s), .cout(mid_c)
        );

        // The two stage carries share weight 2^H and never both rise,
        // because cross sum plus upper low-by-low stays below 2^(W+1).
        always_comb top_addend = {{(H-1){1'b0}}, cross_c | mid_c, mid_s[W-1:H]};

        // Stage 3: high-by-high plus the remaining middle bits and carry.
        vc_rca #(.W(W)) u_add_top (
            .x(pr_hh), .y(top_addend), .cin(1'b0), .s(top_s), .cout(top_carry_unused)
        );

        // Concatenate the result columns.
        always_comb p = {top_s, mid_s[H-1:0], pr_ll[H-1:0]};
    end

endmodule

// File: rtl/vc_mult.sv
// Top of the unsigned vertical-crosswise multiplier. Combinational;
// the product is twice the operand width.
// Assumes: WIDTH is 4 or 8.
module vc_mult
    import vc_mul_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic [2*WIDTH-1:0] prod
);

    localparam int PW = prod_width(WIDTH);

    logic [PW-1:0] node_p;

    vc_mul_node #(.W(WIDTH)) u_root (.a(op_a), .b(op_b), .p(node_p));

    // Drive the product port from the root node.
    always_comb prod = node_p;

endmodule

// File: rtl/vc_mult_chk.sv
// Checker for vc_mult: relates the product port to the operand
// ports whenever they change. Bound to every vc_mult instance.
// Assumes: the block is combinational, so immediate checks suffice.
module vc_mult_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0]   op_a,
    input logic [WIDTH-1:0]   op_b,
    input logic [2*WIDTH-1:0] prod
);

    localparam int PW = 2 * WIDTH;
    localparam logic [PW-1:0] ONES = {{WIDTH{1'b0}}, {WIDTH{1'b1}}};
    localparam logic [PW-1:0] PMAX = ONES * ONES;

    logic [PW-1:0] ref_p;

    // Reference product from the operand ports.
    always_comb ref_p = PW'(op_a) * PW'(op_b);

    // Exact product, no truncation, LSB, zero and unity relations.
    always_comb begin
        // R1 R2
        mul_exact_chk: assert (prod == ref_p);
        // R3
        no_overflow_chk: assert (prod <= PMAX);
        // R4
        lsb_chk: assert (prod[0] == (op_a[0] & op_b[0]));
        // R5
        if (op_a == '0 || op_b == '0) zero_chk: assert (prod == '0);
        // R6
        if (op_b == WIDTH'(1)) unity_chk: assert (prod == PW'(op_a));
    end

endmodule

bind vc_mult vc_mult_chk #(.WIDTH(WIDTH)) u_chk (.op_a(op_a), .op_b(op_b), .prod(prod));

// File: tb/vc_mult_tb.sv
// Directed bench for vc_mult at both supported widths.
module vc_mult_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0]  a8, b8;
    logic [15:0] p8;
    logic [3:0]  a4, b4;
    logic [7:0]  p4;

    vc_mult #(.WIDTH(8)) u_dut  (.op_a(a8), .op_b(b8), .prod(p8));
    vc_mult #(.WIDTH(4)) u_dut4 (.op_a(a4), .op_b(b4), .prod(p4));

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // Compare one value and report a mismatch.
    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply both operand pairs on a falling edge; results read before the rise.
    task automatic drive(input logic [7:0] x8, input logic [7:0] y8,
                         input logic [3:0] x4, input logic [3:0] y4);
        @(negedge clk);
        a8 = x8; b8 = y8; a4 = x4; b4 = y4;
        #1;
    endtask

    // R5: zero operands at start-up give zero.
    task automatic t_start_zero();
        drive(8'h00, 8'h00, 4'h0, 4'h0);
        check("R5 start 8", p8, 16'h0);
        check("R5 start 4", {8'h0, p4}, 16'h0);
        drive(8'hA7, 8'h00, 4'h0, 4'hB);
        check("R5 b zero 8", p8, 16'h0);
        check("R5 a zero 4", {8'h0, p4}, 16'h0);
    endtask

    // R7: the 4 x 4 example case.
    task automatic t_example();
        drive(8'h04, 8'h04, 4'b0100, 4'b0100);
        check("R7 4b", {8'h0, p4}, 16'h0010);
        check("R7 8b", p8, 16'h0010);
    endtask

    // R6: multiply by one returns the other operand.
    task automatic t_unity();
        drive(8'hC3, 8'h01, 4'h1, 4'hD);
        check("R6 8", p8, 16'h00C3);
        check("R6 4", {8'h0, p4}, 16'h000D);
    endtask

    // R3: all-ones and unbalanced cross-term corners.
    task automatic t_max();
        drive(8'hFF, 8'hFF, 4'hF, 4'hF);
        check("R3 max 8", p8, 16'hFE01);
        check("R3 max 4", {8'h0, p4}, 16'h00E1);
        drive(8'hF0, 8'h0F, 4'hC, 4'h3);
        check("R3 cross 8", p8, 16'h0E10);
        check("R3 cross 4", {8'h0, p4}, 16'h0024);
    endtask

    // R4: LSB of the product for each operand-LSB combination.
    task automatic t_lsb();
        for (int k = 0; k < 4; k++) begin
            drive({7'h35, k[0]}, {7'h2A, k[1]}, {3'h5, k[0]}, {3'h6, k[1]});
            check("R4 lsb 8", {15'h0, p8[0]}, {15'h0, k[0] & k[1]});
            check("R4 lsb 4", {15'h0, p4[0]}, {15'h0, k[0] & k[1]});
        end
    endtask

    // R8: change operands between edges and read in the same step.
    task automatic t_comb();
        @(posedge clk);
        #2;
        a8 = 8'h12; b8 = 8'h34; a4 = 4'h7; b4 = 4'h9;
        #1;
        check("R8 8", p8, 16'h03A8);
        check("R8 4", {8'h0, p4}, 16'h003F);
        a8 = 8'h81; b8 = 8'h02; a4 = 4'hE; b4 = 4'h2;
        #1;
        check("R8 8 again", p8, 16'h0102);
        check("R8 4 again", {8'h0, p4}, 16'h001C);
    endtask

    // R2: every 4-bit operand pair.
    task automatic t_exh4();
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                drive(8'h0, 8'h0, i[3:0], j[3:0]);
                check("R2 exhaustive", {8'h0, p4}, 16'(i * j));
            end
        end
    endtask

    // R1: every 8-bit operand pair.
    task automatic t_exh8();
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                drive(i[7:0], j[7:0], 4'h0, 4'h0);
                check("R1 exhaustive", p8, 16'(i * j));
            end
        end
    endtask

    // Watchdog: counts clock cycles and ends a hung run as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!done && cycles > WD_LIMIT) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WD_LIMIT);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Scenario sequence.
    initial begin
        a8 = '0; b8 = '0; a4 = '0; b4 = '0;
        t_start_zero();
        t_example();
        t_unity();
        t_max();
        t_lsb();
        t_comb();
        t_exh4();
        t_exh8();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule